// File: doc/BRIEF.md
# Narrow-Bus Pixel Word Assembler

This block sits behind a narrow parallel host bus and turns a series of bus transfers into complete 18-bit RGB pixel words, with 6 bits each for red, green and blue. Each accepted transfer is marked by a one-cycle strobe. A set of mode inputs selects how many transfers make up one pixel and which bus lanes carry the colour bits. In the two-transfer format all eight bus bits are used. In the three-transfer format each transfer carries one colour channel on the upper six bus bits. One mode code is reserved: it produces no pixels and raises an error flag.

When the last transfer of a pixel is taken, the block emits the assembled word together with a one-cycle valid pulse. The word is then handed to separate address and memory-write logic. A resync pulse, or any change on the mode inputs, throws away a partly assembled pixel, so a host that has lost step can start again from a clean first transfer.

Top module: `pxw_assembler`

## Requirements
- R1: While reset (rst_n low) is held, pix_valid, fmt_error and pix_word are all 0.
- R2: Mode decode. triple_mode=0 selects the two-transfer format for any fmt_sel value. triple_mode=1 with fmt_sel=2'b10 is the reserved code. triple_mode=1 with any other fmt_sel value selects the three-transfer format.
- R3: In the three-transfer format, bus_data[7:2] of transfers one, two and three land in pix_word[17:12] (red), pix_word[11:6] (green) and pix_word[5:0] (blue). bus_data[1:0] is ignored.
- R4: In the two-transfer format, the first transfer gives red = bus_data[7:2] and green bits 5..4 = bus_data[1:0]. The second transfer gives green bits 3..0 = bus_data[7:4] and blue bits 5..2 = bus_data[3:0]. Blue bits 1..0 are copies of blue bits 5..4.
- R5: pix_valid is high for exactly one cycle, namely the cycle after the clock edge that accepts the last transfer of a pixel. pix_word changes only together with that pulse and otherwise holds its value.
- R6: While the reserved code is applied, strobes are ignored and no pixel is produced. fmt_error goes high one cycle after the code is applied, stays high while it remains, and clears one cycle after the mode leaves it.
- R7: A resync pulse discards any partial pixel. A strobe in the same cycle as resync is discarded as well.
- R8: Any change of {triple_mode, fmt_sel} from the previous cycle discards a partial pixel. A strobe in the cycle of the change counts as the first transfer in the new mode.
- R9: Strobes on consecutive cycles are all accepted, so a new pixel can complete every two (or three) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 8 | Bus lanes; bit 7 is the topmost lane |
| bus_strobe | input | 1 | One-cycle transfer strobe |
| triple_mode | input | 1 | Selects the three-transfer family |
| fmt_sel | input | 2 | Format code within the family |
| resync | input | 1 | Discards the partial pixel |
| pix_word | output | 18 | Assembled pixel {R, G, B} |
| pix_valid | output | 1 | One-cycle pulse with a new pixel |
| fmt_error | output | 1 | Reserved mode in use |

## Verification
The hardest situations to create from the ports are the ones where a half-built pixel must be thrown away without any visible output: a mode switch that coincides with a strobe, and a resync that coincides with one. The bench stops a transfer sequence part-way through, applies the mode change or resync in the same cycle as a strobe, and then sends a full fresh pixel. If the dropped data had been kept, it would show up in the next word, or pix_valid would come one transfer early. The reserved code gets the same treatment: the bench sends strobes while the code is applied and checks that the held word does not change.

// File: rtl/pxw_pkg.sv
package pxw_pkg;

    typedef enum logic [1:0] {
        FMT_PAIR   = 2'd0,
        FMT_TRIPLE = 2'd1,
        FMT_RSVD   = 2'd2
    } fmt_kind_e;

    localparam logic [1:0] RSVD_CODE = 2'b10;

endpackage

// File: rtl/pxw_mode_decode.sv
module pxw_mode_decode
    import pxw_pkg::*;
(
    input  logic       triple_mode,
    input  logic [1:0] fmt_sel,
    output fmt_kind_e  kind,
    output logic [1:0] last_phase
);

    always_comb begin
        if (!triple_mode) begin
            kind       = FMT_PAIR;
            last_phase = 2'd1;
        end else if (fmt_sel == RSVD_CODE) begin
            kind       = FMT_RSVD;
            last_phase = 2'd0;
        end else begin
            kind       = FMT_TRIPLE;
            last_phase = 2'd2;
        end
    end

endmodule

// File: rtl/pxw_lane_merge.sv
module pxw_lane_merge #(
    parameter  int CH_W    = 6,
    localparam int BUS_W   = CH_W + 2,
    localparam int PIX_W   = 3 * CH_W,
    localparam int GHI_W   = BUS_W - CH_W,
    localparam int GLO_W   = CH_W - GHI_W,
    localparam int BHI_W   = BUS_W - GLO_W,
    localparam int BFILL_W = CH_W - BHI_W
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [CH_W-1:0]  hold_a,
    input  logic [CH_W-1:0]  hold_b,
    output logic [CH_W-1:0]  pair_red,
    output logic [CH_W-1:0]  pair_grn_hi,
    output logic [PIX_W-1:0] pair_word,
    output logic [CH_W-1:0]  tri_chan,
    output logic [PIX_W-1:0] tri_word
);

    logic [CH_W-1:0] pair_grn;
    logic [CH_W-1:0] pair_blu;

    always_comb begin
        pair_red    = bus[BUS_W-1 -: CH_W];
        pair_grn_hi = {bus[GHI_W-1:0], {GLO_W{1'b0}}};
        pair_grn    = {hold_b[CH_W-1 -: GHI_W], bus[BUS_W-1 -: GLO_W]};
        pair_blu    = {bus[BHI_W-1:0], bus[BHI_W-1 -: BFILL_W]};
        pair_word   = {hold_a, pair_grn, pair_blu};
        tri_chan    = bus[BUS_W-1 -: CH_W];
        tri_word    = {hold_a, hold_b, tri_chan};
    end

endmodule

// File: rtl/pxw_assembler.sv
module pxw_assembler
    import pxw_pkg::*;
#(
    parameter  int CH_W  = 6,
    localparam int BUS_W = CH_W + 2,
    localparam int PIX_W = 3 * CH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_data,
    input  logic             bus_strobe,
    input  logic             triple_mode,
    input  logic [1:0]       fmt_sel,
    input  logic             resync,
    output logic [PIX_W-1:0] pix_word,
    output logic             pix_valid,
    output logic             fmt_error
);

    typedef struct packed {
        logic [1:0]       phase;
        logic [CH_W-1:0]  hold_a;
        logic [CH_W-1:0]  hold_b;
        logic [2:0]       mode;
        logic [PIX_W-1:0] word;
        logic             valid;
        logic             err;
    } state_t;

    state_t st_d, st_q;

    fmt_kind_e        kind;
    logic [1:0]       last_phase;
    logic [CH_W-1:0]  pair_red, pair_grn_hi, tri_chan;
    logic [PIX_W-1:0] pair_word, tri_word;
    logic [2:0]       mode_in;
    logic [1:0]       phase_eff;
    logic             is_last;

    pxw_mode_decode i_decode (
        .triple_mode (triple_mode),
        .fmt_sel     (fmt_sel),
        .kind        (kind),
        .last_phase  (last_phase)
    );

    pxw_lane_merge #(.CH_W(CH_W)) i_merge (
        .bus         (bus_data),
        .hold_a      (st_q.hold_a),
        .hold_b      (st_q.hold_b),
        .pair_red    (pair_red),
        .pair_grn_hi (pair_grn_hi),
        .pair_word   (pair_word),
        .tri_chan    (tri_chan),
        .tri_word    (tri_word)
    );

    always_comb begin
        mode_in   = {triple_mode, fmt_sel};
        phase_eff = (mode_in != st_q.mode) ? 2'd0 : st_q.phase;
        is_last   = (phase_eff == last_phase);

        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.mode  = mode_in;
        st_d.err   = (kind == FMT_RSVD);
        st_d.phase = phase_eff;

        if (resync) begin
            st_d.phase = 2'd0;
        end else if (bus_strobe && kind != FMT_RSVD) begin
            if (kind == FMT_PAIR) begin
                if (is_last) begin
                    st_d.word = pair_word;
                end else begin
                    st_d.hold_a = pair_red;
                    st_d.hold_b = pair_grn_hi;
                end
            end else begin
                if (is_last) begin
                    st_d.word = tri_word;
                end else if (phase_eff == 2'd0) begin
                    st_d.hold_a = tri_chan;
                end else begin
                    st_d.hold_b = tri_chan;
                end
            end
            st_d.valid = is_last;
            st_d.phase = is_last ? 2'd0 : phase_eff + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_word  = st_q.word;
    assign pix_valid = st_q.valid;
    assign fmt_error = st_q.err;

endmodule

// File: rtl/pxw_assembler_chk.sv
module pxw_assembler_chk #(
    parameter  int CH_W    = 6,
    localparam int BUS_W   = CH_W + 2,
    localparam int PIX_W   = 3 * CH_W,
    localparam int BFILL_W = CH_W - 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [BUS_W-1:0] bus_data,
    input logic             bus_strobe,
    input logic             triple_mode,
    input logic [1:0]       fmt_sel,
    input logic             resync,
    input logic [PIX_W-1:0] pix_word,
    input logic             pix_valid,
    input logic             fmt_error
);

    logic started;
    logic rsvd_in;

    assign rsvd_in = triple_mode && (fmt_sel == pxw_pkg::RSVD_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid);

    a_r5_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !pix_valid) |-> $stable(pix_word));

    a_r6_err_tracks_mode: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (fmt_error == $past(rsvd_in)));

    a_r6_no_pixel_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(rsvd_in)) |-> !pix_valid);

    a_r7_resync_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(resync)) |-> !pix_valid);

    a_r3_blue_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (started && pix_valid && $past(triple_mode && !rsvd_in))
        |-> (pix_word[CH_W-1:0] == $past(bus_data[BUS_W-1 -: CH_W])));

    a_r4_blue_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (started && pix_valid && $past(!triple_mode))
        |-> (pix_word[BFILL_W-1:0] == pix_word[CH_W-1 -: BFILL_W]));

    a_r4_blue_high: assert property (@(posedge clk) disable iff (!rst_n)
        (started && pix_valid && $past(!triple_mode))
        |-> (pix_word[CH_W-1 -: 4] == $past(bus_data[3:0])));

endmodule

bind pxw_assembler pxw_assembler_chk #(.CH_W(CH_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_data    (bus_data),
    .bus_strobe  (bus_strobe),
    .triple_mode (triple_mode),
    .fmt_sel     (fmt_sel),
    .resync      (resync),
    .pix_word    (pix_word),
    .pix_valid   (pix_valid),
    .fmt_error   (fmt_error)
);

// File: tb/test_pxw_assembler.sv
`timescale 1ns/1ps
module test_pxw_assembler;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_data = '0;
    logic        bus_strobe = 1'b0;
    logic        triple_m = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic        resync = 1'b0;
    logic [17:0] pix_word;
    logic        pix_valid;
    logic        fmt_error;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    pxw_assembler i_pxw_assembler (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_strobe(bus_strobe),
        .triple_mode(triple_m), .fmt_sel(fmt), .resync(resync),
        .pix_word(pix_word), .pix_valid(pix_valid), .fmt_error(fmt_error)
    );

    typedef struct packed {
        logic       trip;
        logic [1:0] fm;
        logic [5:0] r;
        logic [5:0] g;
        logic [5:0] b;
        logic [1:0] junk;
        logic [5:0] xb;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 2'b00, 6'h2A, 6'h15, 6'h3C, 2'b00, 6'h3F},
        '{1'b0, 2'b11, 6'h01, 6'h3E, 6'h23, 2'b00, 6'h22},
        '{1'b0, 2'b10, 6'h3F, 6'h00, 6'h14, 2'b00, 6'h15},
        '{1'b1, 2'b11, 6'h12, 6'h2D, 6'h07, 2'b11, 6'h07},
        '{1'b1, 2'b00, 6'h3F, 6'h00, 6'h3F, 2'b01, 6'h3F},
        '{1'b1, 2'b01, 6'h05, 6'h2A, 6'h19, 2'b10, 6'h19}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the following negedge.
    task automatic xfer(input logic [7:0] d, input logic rs);
        bus_data   = d;
        bus_strobe = 1'b1;
        resync     = rs;
        @(negedge clk);
        bus_strobe = 1'b0;
        resync     = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [17:0] held;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 valid in reset", pix_valid, 0);
        check("R1 error in reset", fmt_error, 0);
        check("R1 word in reset", pix_word, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2, R3, R4, R5
        for (int i = 0; i < 6; i++) begin
            triple_m = VECS[i].trip;
            fmt      = VECS[i].fm;
            @(negedge clk);
            if (!VECS[i].trip) begin
                xfer({VECS[i].r, VECS[i].g[5:4]}, 1'b0);
                check("R2 pair no early valid", pix_valid, 0);
                xfer({VECS[i].g[3:0], VECS[i].b[5:2]}, 1'b0);
                check("R4 pair valid", pix_valid, 1);
            end else begin
                xfer({VECS[i].r, VECS[i].junk}, 1'b0);
                xfer({VECS[i].g, VECS[i].junk}, 1'b0);
                check("R2 triple no early valid", pix_valid, 0);
                xfer({VECS[i].b, VECS[i].junk}, 1'b0);
                check("R3 triple valid", pix_valid, 1);
            end
            check("R3/R4 word", pix_word, {VECS[i].r, VECS[i].g, VECS[i].xb});
            held = pix_word;
            @(negedge clk);
            check("R5 pulse one cycle", pix_valid, 0);
            @(negedge clk);
            check("R5 word holds", pix_word, held);
        end

        // R6 reserved mode
        triple_m = 1'b1; fmt = 2'b10;
        held = pix_word;
        @(negedge clk);
        check("R6 error raised", fmt_error, 1);
        for (int k = 0; k < 3; k++) begin
            xfer({6'h11, 2'b00}, 1'b0);
            check("R6 no valid in reserved", pix_valid, 0);
        end
        check("R6 word untouched", pix_word, held);
        check("R6 error held", fmt_error, 1);
        fmt = 2'b11;
        @(negedge clk);
        check("R6 error cleared", fmt_error, 0);
        xfer({6'h31, 2'b00}, 1'b0);
        xfer({6'h32, 2'b00}, 1'b0);
        xfer({6'h33, 2'b00}, 1'b0);
        check("R6 clean pixel after", pix_word, {6'h31, 6'h32, 6'h33});

        // R7 resync alone
        xfer({6'h01, 2'b00}, 1'b0);
        resync = 1'b1;
        @(negedge clk);
        resync = 1'b0;
        xfer({6'h0A, 2'b00}, 1'b0);
        xfer({6'h0B, 2'b00}, 1'b0);
        check("R7 resync restarts count", pix_valid, 0);
        xfer({6'h0C, 2'b00}, 1'b0);
        check("R7 valid after resync", pix_valid, 1);
        check("R7 word after resync", pix_word, {6'h0A, 6'h0B, 6'h0C});

        // R7 resync together with strobe
        xfer({6'h02, 2'b00}, 1'b0);
        xfer({6'h03, 2'b00}, 1'b1);
        check("R7 strobe with resync dropped", pix_valid, 0);
        xfer({6'h1A, 2'b00}, 1'b0);
        xfer({6'h1B, 2'b00}, 1'b0);
        xfer({6'h1C, 2'b00}, 1'b0);
        check("R7 word after resync strobe", pix_word, {6'h1A, 6'h1B, 6'h1C});

        // R8 mode change with strobe in the same cycle
        triple_m = 1'b0;
        @(negedge clk);
        xfer(8'hFF, 1'b0);
        triple_m = 1'b1; fmt = 2'b11;
        xfer({6'h21, 2'b00}, 1'b0);
        check("R8 no pair pixel on change", pix_valid, 0);
        xfer({6'h0C, 2'b00}, 1'b0);
        check("R8 second transfer", pix_valid, 0);
        xfer({6'h33, 2'b00}, 1'b0);
        check("R8 valid in new mode", pix_valid, 1);
        check("R8 word in new mode", pix_word, {6'h21, 6'h0C, 6'h33});

        // R9 back-to-back strobes
        @(negedge clk);
        bus_strobe = 1'b1;
        for (int k = 0; k < 6; k++) begin
            bus_data = {6'(k + 8), 2'b00};
            @(negedge clk);
            check("R9 valid cadence", pix_valid, (k % 3 == 2) ? 1 : 0);
            if (k == 2) check("R9 first word", pix_word, {6'd8, 6'd9, 6'd10});
            if (k == 5) check("R9 second word", pix_word, {6'd11, 6'd12, 6'd13});
        end
        bus_strobe = 1'b0;
        @(negedge clk);
        check("R9 idle after burst", pix_valid, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule